// File: doc/BRIEF.md
# Seven-Segment Countdown Timer

The block drives one seven-segment digit that counts down once every half second. A free-running peripheral clock of 2.45 MHz feeds a two-stage divider. The first stage is a periodic rate generator: with its default limit of 24,500 it raises a one-cycle strobe every 10 ms. The second stage counts 50 of those strobes and raises its own one-cycle strobe every 0.5 s.

Each half-second strobe moves a decimal digit one place down: 9, 8, and so on to 0, then back to 9. The digit is decoded into an active-high segment byte. Both strobes are also brought out as ports, so nearby logic can use them as periodic event requests. An enable input freezes all counting without losing position. A synchronous reset restarts the sequence from 9.

Top module: `seg_countdown`

## Requirements
- R1: While `en` is high, `tick_o` is high for exactly one cycle in every TICK_DIV cycles (default 24,500, giving 10 ms at 2.45 MHz). After reset is released with `en` high, the first tick is high in the cycle that follows the (TICK_DIV-1)-th rising edge.
- R2: `step_o` is high for one cycle, in the same cycle as every TICKS_PER_STEP-th tick (default 50, giving 0.5 s). It is never high unless `tick_o` is also high, and the second stage restarts without skipping a tick.
- R3: The digit changes only at the clock edge that ends a cycle with `step_o` high. It falls by one, and it goes from 0 back to 9.
- R4: `seg_o` bit 0 is segment a, bits 1 to 6 are b, c, d, e, f, g, and bit 7 is the decimal point. A 1 lights the segment. Digits 0 to 9 encode as 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F.
- R5: `seg_o` bit 7 (decimal point) is always 0.
- R6: While `rst` is high at a rising edge, the digit is loaded with 9 and both dividers are cleared. From the next cycle `seg_o` is 0x6F and both strobes are low, and counting restarts as in R1. This holds in the middle of a run as well.
- R7: While `en` is low, `tick_o` and `step_o` stay low and `seg_o` does not change. Both dividers hold their counts, so once `en` returns high the next tick and step arrive as though the disabled cycles had not occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock (2.45 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, active high |
| seg_o | output | 8 | Segment byte, {dp,g,f,e,d,c,b,a}, active high |
| tick_o | output | 1 | One-cycle strobe at the first-stage rate (10 ms) |
| step_o | output | 1 | One-cycle strobe at the second-stage rate (0.5 s) |

## Verification
A first-stage count that is off shows at once in the spacing of `tick_o`. An error in the second stage shows as a `step_o` on the wrong tick within one step period. A bad digit register or decoder shows on `seg_o` in the cycle after the step that exposes it, and the decode of every digit is seen during one full cycle of ten steps. State that leaks while `en` is low only shows once counting resumes, so the bench measures the distance to the next tick and to the next step after re-enabling, and compares both with the distances the held counts predict.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int DIGIT_W   = 4;
    localparam int SEG_W     = 8;
    localparam int DIGIT_TOP = 9;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [SEG_W-1:0]   seg_t;

    typedef struct packed {
        digit_t digit;
    } digit_state_t;

    // Bit order {dp,g,f,e,d,c,b,a}; a set bit lights the segment.
    function automatic seg_t seg_encode(input digit_t d);
        seg_t s;
        case (d)
            4'd0:    s = 8'h3F;
            4'd1:    s = 8'h06;
            4'd2:    s = 8'h5B;
            4'd3:    s = 8'h4F;
            4'd4:    s = 8'h66;
            4'd5:    s = 8'h6D;
            4'd6:    s = 8'h7D;
            4'd7:    s = 8'h07;
            4'd8:    s = 8'h7F;
            4'd9:    s = 8'h6F;
            default: s = 8'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sc_divider.sv
module sc_divider #(
    parameter int LIMIT = 24500
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    output logic wrap
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.cnt == LAST);
        wrap    = inc && at_last;
        if (inc) begin
            st_d.cnt = at_last ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LAST);

    assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (rst)
        wrap |=> st_q.cnt == '0);

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(st_q.cnt));

endmodule

// File: rtl/sc_digit.sv
module sc_digit
    import sc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step,
    output seg_t seg_o
);

    digit_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (st_q.digit == '0) begin
                st_d.digit = digit_t'(DIGIT_TOP);
            end else begin
                st_d.digit = st_q.digit - 1'b1;
            end
        end
        seg_o = seg_encode(st_q.digit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.digit <= digit_t'(DIGIT_TOP);
        end else begin
            st_q <= st_d;
        end
    end

    assert_digit_range_R3: assert property (@(posedge clk) disable iff (rst)
        st_q.digit <= digit_t'(DIGIT_TOP));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
        (step && st_q.digit != '0) |=> st_q.digit == $past(st_q.digit) - 1'b1);

    assert_wrap_nine_R3: assert property (@(posedge clk) disable iff (rst)
        (step && st_q.digit == '0) |=> st_q.digit == digit_t'(DIGIT_TOP));

    assert_hold_digit_R7: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(st_q.digit));

    assert_dp_dark_R5: assert property (@(posedge clk) disable iff (rst)
        seg_o[SEG_W-1] == 1'b0);

    assert_reset_nine_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> seg_o == 8'h6F);

endmodule

// File: rtl/seg_countdown.sv
module seg_countdown
    import sc_pkg::*;
#(
    parameter int TICK_DIV       = 24500,
    parameter int TICKS_PER_STEP = 50
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    output logic [7:0] seg_o,
    output logic       tick_o,
    output logic       step_o
);

    logic tick_w;
    logic step_w;
    seg_t seg_w;

    sc_divider #(.LIMIT(TICK_DIV)) i_tick_div (
        .clk  (clk),
        .rst  (rst),
        .inc  (en),
        .wrap (tick_w)
    );

    sc_divider #(.LIMIT(TICKS_PER_STEP)) i_step_div (
        .clk  (clk),
        .rst  (rst),
        .inc  (tick_w),
        .wrap (step_w)
    );

    sc_digit i_digit (
        .clk   (clk),
        .rst   (rst),
        .step  (step_w),
        .seg_o (seg_w)
    );

    assign seg_o  = seg_w;
    assign tick_o = tick_w;
    assign step_o = step_w;

    assert_step_with_tick_R2: assert property (@(posedge clk) disable iff (rst)
        step_o |-> tick_o);

    assert_quiet_disabled_R7: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!tick_o && !step_o));

endmodule

// File: tb/test_seg_countdown.sv
`timescale 1ns/1ps
module test_seg_countdown;

    localparam int D = 5;
    localparam int N = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b1;
    logic [7:0] seg;
    logic       tick;
    logic       step;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    seg_countdown #(.TICK_DIV(D), .TICKS_PER_STEP(N)) i_seg_countdown (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .seg_o  (seg),
        .tick_o (tick),
        .step_o (step)
    );

    function automatic logic [7:0] exp_seg(input int d);
        case (d)
            0: return 8'h3F;  1: return 8'h06;  2: return 8'h5B;
            3: return 8'h4F;  4: return 8'h66;  5: return 8'h6D;
            6: return 8'h7D;  7: return 8'h07;  8: return 8'h7F;
            default: return 8'h6F;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Counts negedges until the chosen strobe is seen high.
    task automatic wait_pulse(input bit want_step, output int n);
        n = 0;
        while ((want_step ? step : tick) !== 1'b1 && n < 10000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(seg == 8'h6F, "R6", "seg in reset", seg, 8'h6F);
        chk(tick == 1'b0 && step == 1'b0, "R6", "strobes in reset", {tick, step}, 0);
        rst = 1'b0;
        chk(seg == 8'h6F, "R6", "seg after release", seg, 8'h6F);
    endtask

    task automatic t_tick();
        int n;
        do_reset();
        wait_pulse(1'b0, n);
        chk(n == D - 1, "R1", "cycles to first tick", n, D - 1);
        @(negedge clk);
        chk(tick == 1'b0, "R1", "tick width", tick, 0);
        wait_pulse(1'b0, n);
        chk(n + 1 == D, "R1", "tick period", n + 1, D);
    endtask

    task automatic t_step();
        int ticks = 0;
        int cyc   = 0;
        int bad   = 0;
        do_reset();
        while (step !== 1'b1 && cyc < 10000) begin
            if (tick) ticks++;
            @(negedge clk);
            cyc++;
        end
        if (tick) ticks++;
        chk(ticks == N, "R2", "ticks per step", ticks, N);
        chk(cyc == N * D - 1, "R2", "cycles to first step", cyc, N * D - 1);
        chk(tick == 1'b1, "R2", "step coincides with tick", tick, 1);
        @(negedge clk);
        chk(step == 1'b0, "R2", "step width", step, 0);
        for (int i = 0; i < 3 * N * D; i++) begin
            if (step && !tick) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R2", "step without tick", bad, 0);
    endtask

    task automatic t_sequence();
        int n;
        int d = 9;
        do_reset();
        for (int i = 0; i < 11; i++) begin
            wait_pulse(1'b1, n);
            chk(n == N * D - 1, "R2", "step spacing", n, N * D - 1);
            chk(seg == exp_seg(d), "R4", "segments before step", seg, exp_seg(d));
            @(negedge clk);
            d = (d == 0) ? 9 : d - 1;
            chk(seg == exp_seg(d), "R3", "digit after step", seg, exp_seg(d));
            chk(seg[7] == 1'b0, "R5", "decimal point", seg[7], 0);
        end
    endtask

    task automatic t_enable();
        int n;
        int m;
        int noisy = 0;
        logic [7:0] held;
        do_reset();
        repeat (7) @(negedge clk);
        en   = 1'b0;
        held = seg;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (tick || step || seg != held) noisy++;
        end
        chk(noisy == 0, "R7", "activity while disabled", noisy, 0);
        en = 1'b1;
        wait_pulse(1'b0, n);
        chk(n == D - 3, "R7", "cycles to tick after resume", n, D - 3);
        @(negedge clk);
        wait_pulse(1'b1, m);
        chk(n + 1 + m == (D - 3) + (N - 2) * D, "R7", "cycles to step after resume",
            n + 1 + m, (D - 3) + (N - 2) * D);
    endtask

    task automatic t_midreset();
        int n;
        do_reset();
        for (int i = 0; i < 3; i++) begin
            wait_pulse(1'b1, n);
            @(negedge clk);
        end
        chk(seg == exp_seg(6), "R3", "digit after three steps", seg, exp_seg(6));
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(seg == 8'h6F, "R6", "seg after mid-run reset", seg, 8'h6F);
        wait_pulse(1'b0, n);
        chk(n == D - 1, "R6", "tick restart after reset", n, D - 1);
        wait_pulse(1'b1, n);
        chk(n == (N - 1) * D, "R6", "step restart after reset", n, (N - 1) * D);
    endtask

    initial begin
        t_reset();
        t_tick();
        t_step();
        t_sequence();
        t_enable();
        t_midreset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule